// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the hazard control for a five-stage in-order pipeline. Each cycle it compares the source registers of the instruction in decode with the destination registers of the instructions in execute, memory and writeback. For each operand it returns a bypass select that tells the decode-stage operand multiplexer where the value should come from. The value is taken at the end of decode, either from the register file or from the end of a later stage.

Two situations cannot be covered by bypassing, and for these the block raises stall and bubble controls. The first is a load whose result a dependent instruction needs in the next cycle. The decode and fetch registers then hold their contents for one cycle while execute receives a bubble. The second is a return, whose target is known only late. Fetch is held for a fixed window while decode receives bubbles.

The block is combinational apart from a small counter that tracks the return window. The datapath, register file and memory are outside it.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When an ALU (non-load) instruction in execute writes a register that a decode operand reads, that operand's select is 1 (end of execute) and no stall is raised. Select encoding: 0 register file, 1 execute, 2 memory, 3 writeback.
- R2: When the youngest matching producer sits in the memory stage, the operand's select is 2, whether or not that producer is a load.
- R3: When the only matching producer sits in writeback, the operand's select is 3.
- R4: When several valid stages write the register an operand reads, the youngest producer wins, in the order execute, then memory, then writeback.
- R5: When a load in execute writes a register that a valid decode operand reads, fetch_stall, dec_stall and exe_bubble are all 1 for that cycle, dec_bubble is 0 and that operand's select is 0. Once the load has moved to memory with a bubble behind it, the operand selects 2 and the stall is gone.
- R6: Each operand chooses its source on its own. One operand may bypass from memory while the other bypasses from execute, and a load hit on only one operand still stalls the instruction.
- R7: When dec_sp_read is 1, operand B is compared against register 4 (the stack pointer) in place of dec_src_b. When dec_sp_read is 0, register 4 is not implied.
- R8: Register ID 15 means "no register" and never matches. Stages whose valid bit is 0 never match. An invalid decode entry yields select 0 and no stall.
- R9: A return in a valid decode entry holds fetch_stall and dec_bubble high for exactly 3 consecutive cycles, counting the cycle in which the return sits in decode.
- R10: When a return in decode also hits a load-use hazard, the load-use stall takes precedence: dec_bubble stays 0 and the return stays in decode. Its 3-cycle window starts in the cycle after the stall.
- R11: Reset clears the return window, so with idle inputs after reset no stall or bubble is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_src_a | input | 4 | Decode operand A source register |
| dec_src_b | input | 4 | Decode operand B source register |
| dec_sp_read | input | 1 | Instruction reads the stack pointer implicitly through operand B |
| dec_is_ret | input | 1 | Decode instruction is a return |
| exe_valid | input | 1 | Execute holds a real instruction |
| exe_dst | input | 4 | Execute destination register |
| exe_is_load | input | 1 | Execute instruction is a memory load |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_dst | input | 4 | Memory-stage destination register |
| wb_valid | input | 1 | Writeback holds a real instruction |
| wb_dst | input | 4 | Writeback destination register |
| fwd_sel_a | output | 2 | Operand A bypass select |
| fwd_sel_b | output | 2 | Operand B bypass select |
| fetch_stall | output | 1 | Hold the fetch register |
| dec_stall | output | 1 | Hold the decode register |
| dec_bubble | output | 1 | Load a bubble into decode |
| exe_bubble | output | 1 | Load a bubble into execute |

## Verification
The bench uses the default parameters: 4-bit register IDs, stack pointer 4, a 3-cycle return window and the writeback bypass enabled. With these values the all-ones "no register" code (15), the implicit stack-pointer comparison and the writeback select value 3 can each be reached directly from the ports. The 3-cycle window is short enough that the bench can count every cycle of a return, including the case where a load-use stall postpones it.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;

   // Bypass source of one decode operand; the order is the port encoding.
   typedef enum logic [1:0] {
      FWD_RF  = 2'd0,
      FWD_EXE = 2'd1,
      FWD_MEM = 2'd2,
      FWD_WB  = 2'd3
   } fwd_src_e;

endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
   import pipe_hz_pkg::*;
#(
   parameter int REG_W       = 4,
   parameter bit FWD_FROM_WB = 1'b1
) (
   input  logic             dec_valid,
   input  logic [REG_W-1:0] src,
   input  logic             exe_valid,
   input  logic [REG_W-1:0] exe_dst,
   input  logic             exe_is_load,
   input  logic             mem_valid,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             wb_valid,
   input  logic [REG_W-1:0] wb_dst,
   output fwd_src_e         sel,
   output logic             load_hit
);

   localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

   logic src_live;
   logic hit_exe;
   logic hit_mem;
   logic hit_wb;

   assign src_live = dec_valid && (src != NO_REG);
   assign hit_exe  = src_live && exe_valid && (exe_dst == src);
   assign hit_mem  = src_live && mem_valid && (mem_dst == src);

   generate
      if (FWD_FROM_WB) begin : g_wb_bypass
         assign hit_wb = src_live && wb_valid && (wb_dst == src);
      end else begin : g_wb_regfile
         // Writeback value reaches decode through a write-first register file.
         assign hit_wb = 1'b0;
      end
   endgenerate

   // Youngest producer wins; a load in execute cannot supply a value yet.
   always_comb begin
      sel = FWD_RF;
      if (hit_exe) begin
         sel = exe_is_load ? FWD_RF : FWD_EXE;
      end else if (hit_mem) begin
         sel = FWD_MEM;
      end else if (hit_wb) begin
         sel = FWD_WB;
      end
   end

   assign load_hit = hit_exe && exe_is_load;

endmodule

// File: rtl/hz_ret_hold.sv
module hz_ret_hold #(
   parameter int RET_STALL = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ret_go,
   output logic hold_active
);

   localparam int            CNT_W  = $clog2(RET_STALL + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RET_STALL - 1);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (ret_go) begin
         left_q <= RELOAD;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign hold_active = (left_q != '0);

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
   import pipe_hz_pkg::*;
#(
   parameter int REG_W       = 4,
   parameter int SP_ID       = 4,
   parameter int RET_STALL   = 3,
   parameter bit FWD_FROM_WB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [REG_W-1:0] dec_src_a,
   input  logic [REG_W-1:0] dec_src_b,
   input  logic             dec_sp_read,
   input  logic             dec_is_ret,
   input  logic             exe_valid,
   input  logic [REG_W-1:0] exe_dst,
   input  logic             exe_is_load,
   input  logic             mem_valid,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             wb_valid,
   input  logic [REG_W-1:0] wb_dst,
   output logic [1:0]       fwd_sel_a,
   output logic [1:0]       fwd_sel_b,
   output logic             fetch_stall,
   output logic             dec_stall,
   output logic             dec_bubble,
   output logic             exe_bubble
);

   localparam int               N_OPS  = 2;
   localparam logic [REG_W-1:0] SP_REG = REG_W'(SP_ID);

   generate
      if (REG_W < 2) begin : g_bad_width
         $error("pipe_hazard_ctl: REG_W must be at least 2");
      end
      if (SP_ID < 0 || SP_ID >= (1 << REG_W) - 1) begin : g_bad_sp
         $error("pipe_hazard_ctl: SP_ID must be a real register, not the no-register code");
      end
      if (RET_STALL < 1) begin : g_bad_ret
         $error("pipe_hazard_ctl: RET_STALL must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0] op_src [N_OPS];
   fwd_src_e         op_sel [N_OPS];
   logic [N_OPS-1:0] op_load_hit;

   // Operand B carries the implicit stack-pointer read.
   assign op_src[0] = dec_src_a;
   assign op_src[1] = dec_sp_read ? SP_REG : dec_src_b;

   generate
      for (genvar g = 0; g < N_OPS; g++) begin : g_op
         hz_operand_sel #(
            .REG_W       (REG_W),
            .FWD_FROM_WB (FWD_FROM_WB)
         ) u_sel (
            .dec_valid   (dec_valid),
            .src         (op_src[g]),
            .exe_valid   (exe_valid),
            .exe_dst     (exe_dst),
            .exe_is_load (exe_is_load),
            .mem_valid   (mem_valid),
            .mem_dst     (mem_dst),
            .wb_valid    (wb_valid),
            .wb_dst      (wb_dst),
            .sel         (op_sel[g]),
            .load_hit    (op_load_hit[g])
         );
      end
   endgenerate

   logic load_use;
   logic dec_ret;
   logic ret_go;
   logic ret_hold;
   logic ret_busy;

   assign load_use = |op_load_hit;
   assign dec_ret  = dec_valid && dec_is_ret;
   assign ret_go   = dec_ret && !load_use;

   hz_ret_hold #(
      .RET_STALL (RET_STALL)
   ) u_ret (
      .clk         (clk),
      .rst_n       (rst_n),
      .ret_go      (ret_go),
      .hold_active (ret_hold)
   );

   assign ret_busy    = dec_ret || ret_hold;
   assign fwd_sel_a   = op_sel[0];
   assign fwd_sel_b   = op_sel[1];
   assign dec_stall   = load_use;
   assign exe_bubble  = load_use;
   assign fetch_stall = load_use || ret_busy;
   assign dec_bubble  = ret_busy && !load_use;

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
   parameter int REG_W     = 4,
   parameter int SP_ID     = 4,
   parameter int RET_STALL = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_valid,
   input logic [REG_W-1:0] dec_src_a,
   input logic             dec_sp_read,
   input logic             dec_is_ret,
   input logic             exe_valid,
   input logic [REG_W-1:0] exe_dst,
   input logic             exe_is_load,
   input logic [1:0]       fwd_sel_a,
   input logic             fetch_stall,
   input logic             dec_stall,
   input logic             dec_bubble,
   input logic             exe_bubble
);

   localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};
   localparam logic [REG_W-1:0] SP_REG = REG_W'(SP_ID);
   localparam int               CW     = $clog2(RET_STALL + 2);
   localparam logic [CW-1:0]    RS     = CW'(RET_STALL);

   // Cycles elapsed since a return left decode.
   logic [CW-1:0] since_ret;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_ret <= '0;
      end else if (dec_valid && dec_is_ret && !dec_stall) begin
         since_ret <= CW'(1);
      end else if (since_ret != '0 && since_ret < RS) begin
         since_ret <= since_ret + 1'b1;
      end else begin
         since_ret <= '0;
      end
   end

   AST_FWD_EXE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && exe_valid && !exe_is_load && exe_dst == dec_src_a && dec_src_a != NO_REG)
      |-> (fwd_sel_a == 2'd1)); // R1

   AST_LOAD_USE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && exe_valid && exe_is_load && exe_dst == dec_src_a && dec_src_a != NO_REG)
      |-> (dec_stall && exe_bubble && fetch_stall && fwd_sel_a == 2'd0)); // R5

   AST_SP_IMPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_sp_read && exe_valid && exe_is_load && exe_dst == SP_REG)
      |-> dec_stall); // R7

   AST_NO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_valid || dec_src_a == NO_REG) |-> (fwd_sel_a == 2'd0)); // R8

   AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      dec_stall |-> (exe_bubble && fetch_stall && !dec_bubble)); // R10

   AST_RET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (since_ret != '0 && since_ret < RS) |-> (fetch_stall && dec_bubble)); // R9

   AST_RET_END: assert property (@(posedge clk) disable iff (!rst_n)
      (since_ret == RS && !(dec_valid && dec_is_ret) && !dec_stall) |-> !fetch_stall); // R9

endmodule

bind pipe_hazard_ctl hz_checker #(
   .REG_W     (REG_W),
   .SP_ID     (SP_ID),
   .RET_STALL (RET_STALL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid),
   .dec_src_a   (dec_src_a),
   .dec_sp_read (dec_sp_read),
   .dec_is_ret  (dec_is_ret),
   .exe_valid   (exe_valid),
   .exe_dst     (exe_dst),
   .exe_is_load (exe_is_load),
   .fwd_sel_a   (fwd_sel_a),
   .fetch_stall (fetch_stall),
   .dec_stall   (dec_stall),
   .dec_bubble  (dec_bubble),
   .exe_bubble  (exe_bubble)
);

// File: tb/pipe_hazard_ctl_test.sv
module pipe_hazard_ctl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_valid = 1'b0;
   logic [3:0] dec_src_a = 4'hF;
   logic [3:0] dec_src_b = 4'hF;
   logic       dec_sp_read = 1'b0;
   logic       dec_is_ret = 1'b0;
   logic       exe_valid = 1'b0;
   logic [3:0] exe_dst = 4'hF;
   logic       exe_is_load = 1'b0;
   logic       mem_valid = 1'b0;
   logic [3:0] mem_dst = 4'hF;
   logic       wb_valid = 1'b0;
   logic [3:0] wb_dst = 4'hF;
   logic [1:0] fwd_sel_a;
   logic [1:0] fwd_sel_b;
   logic       fetch_stall;
   logic       dec_stall;
   logic       dec_bubble;
   logic       exe_bubble;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   pipe_hazard_ctl uut (
      .clk (clk), .rst_n (rst_n),
      .dec_valid (dec_valid), .dec_src_a (dec_src_a), .dec_src_b (dec_src_b),
      .dec_sp_read (dec_sp_read), .dec_is_ret (dec_is_ret),
      .exe_valid (exe_valid), .exe_dst (exe_dst), .exe_is_load (exe_is_load),
      .mem_valid (mem_valid), .mem_dst (mem_dst),
      .wb_valid (wb_valid), .wb_dst (wb_dst),
      .fwd_sel_a (fwd_sel_a), .fwd_sel_b (fwd_sel_b),
      .fetch_stall (fetch_stall), .dec_stall (dec_stall),
      .dec_bubble (dec_bubble), .exe_bubble (exe_bubble)
   );

   typedef struct packed {
      logic [3:0] rq;
      logic       dv;
      logic [3:0] sa;
      logic [3:0] sb;
      logic       sp;
      logic       ev;
      logic [3:0] ed;
      logic       el;
      logic       mv;
      logic [3:0] md;
      logic       wv;
      logic [3:0] wd;
      logic [1:0] xa;
      logic [1:0] xb;
      logic       xf;
      logic       xd;
      logic       xdb;
      logic       xe;
   } vec_t;

   localparam int NV = 16;
   // Fields: req, dv, srcA, srcB, sp, exeV, exeDst, exeLoad, memV, memDst, wbV, wbDst,
   //         expected selA, selB, fetch_stall, dec_stall, dec_bubble, exe_bubble
   localparam vec_t TBL [NV] = '{
      // R1: ALU in execute feeds operand A
      '{4'd1, 1'b1, 4'h3, 4'h5, 1'b0, 1'b1, 4'h3, 1'b0, 1'b0, 4'hF, 1'b0, 4'hF, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R1: both operands from execute
      '{4'd1, 1'b1, 4'h3, 4'h3, 1'b0, 1'b1, 4'h3, 1'b0, 1'b0, 4'hF, 1'b0, 4'hF, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
      // R2: memory stage feeds operand B
      '{4'd2, 1'b1, 4'h2, 4'h6, 1'b0, 1'b1, 4'h9, 1'b0, 1'b1, 4'h6, 1'b0, 4'hF, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
      // R3: writeback feeds operand A
      '{4'd3, 1'b1, 4'h7, 4'h1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 4'hF, 1'b1, 4'h7, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R4: all three write r8, execute wins
      '{4'd4, 1'b1, 4'h8, 4'h8, 1'b0, 1'b1, 4'h8, 1'b0, 1'b1, 4'h8, 1'b1, 4'h8, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
      // R4: memory beats writeback
      '{4'd4, 1'b1, 4'h8, 4'h2, 1'b0, 1'b1, 4'h1, 1'b0, 1'b1, 4'h8, 1'b1, 4'h8, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R5: load in execute, dependent in decode
      '{4'd5, 1'b1, 4'h9, 4'h0, 1'b0, 1'b1, 4'h9, 1'b1, 1'b0, 4'hF, 1'b0, 4'hF, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
      // R5: cycle after, load in memory, bubble in execute
      '{4'd5, 1'b1, 4'h9, 4'h0, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 4'h9, 1'b0, 4'hF, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R6: A from memory (older load), B from execute
      '{4'd6, 1'b1, 4'hB, 4'hC, 1'b0, 1'b1, 4'hC, 1'b0, 1'b1, 4'hB, 1'b0, 4'hF, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
      // R6: load hits only B, A still bypasses from memory, stall raised
      '{4'd6, 1'b1, 4'h5, 4'h6, 1'b0, 1'b1, 4'h6, 1'b1, 1'b1, 4'h5, 1'b0, 4'hF, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
      // R7: implicit stack read vs load of r4
      '{4'd7, 1'b1, 4'h1, 4'h2, 1'b1, 1'b1, 4'h4, 1'b1, 1'b0, 4'hF, 1'b0, 4'hF, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
      // R7: implicit stack read bypassed from memory
      '{4'd7, 1'b1, 4'h1, 4'h2, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 4'h4, 1'b0, 4'hF, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
      // R7: no implicit read, r4 in memory ignored
      '{4'd7, 1'b1, 4'h1, 4'h2, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 4'h4, 1'b0, 4'hF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R8: ID 15 never matches, even a load
      '{4'd8, 1'b1, 4'hF, 4'hF, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 4'hF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R8: invalid stages ignored
      '{4'd8, 1'b1, 4'h3, 4'h3, 1'b0, 1'b0, 4'h3, 1'b1, 1'b0, 4'h3, 1'b0, 4'h3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      // R8: invalid decode entry
      '{4'd8, 1'b0, 4'h3, 4'h3, 1'b0, 1'b1, 4'h3, 1'b1, 1'b1, 4'h3, 1'b0, 4'hF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   task automatic idle();
      dec_valid = 1'b0; dec_src_a = 4'hF; dec_src_b = 4'hF;
      dec_sp_read = 1'b0; dec_is_ret = 1'b0;
      exe_valid = 1'b0; exe_dst = 4'hF; exe_is_load = 1'b0;
      mem_valid = 1'b0; mem_dst = 4'hF; wb_valid = 1'b0; wb_dst = 4'hF;
   endtask

   task automatic expect_out(string tag, logic [1:0] xa, logic [1:0] xb,
                             logic xf, logic xd, logic xdb, logic xe);
      logic [7:0] got;
      logic [7:0] exp;
      got = {fwd_sel_a, fwd_sel_b, fetch_stall, dec_stall, dec_bubble, exe_bubble};
      exp = {xa, xb, xf, xd, xdb, xe};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got selA,selB,fs,ds,db,eb=%b expected %b", tag, got, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R11: a return held in decode during reset must leave no window behind
      idle();
      dec_valid = 1'b1; dec_is_ret = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      idle();
      rst_n = 1'b1;
      #1 expect_out("R11 idle after reset", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         dec_valid = TBL[i].dv; dec_src_a = TBL[i].sa; dec_src_b = TBL[i].sb;
         dec_sp_read = TBL[i].sp; dec_is_ret = 1'b0;
         exe_valid = TBL[i].ev; exe_dst = TBL[i].ed; exe_is_load = TBL[i].el;
         mem_valid = TBL[i].mv; mem_dst = TBL[i].md;
         wb_valid = TBL[i].wv; wb_dst = TBL[i].wd;
         #1 expect_out($sformatf("R%0d vector %0d", TBL[i].rq, i),
                       TBL[i].xa, TBL[i].xb, TBL[i].xf, TBL[i].xd, TBL[i].xdb, TBL[i].xe);
      end

      // R9: return window, three stalled cycles then free
      @(negedge clk);
      idle();
      dec_valid = 1'b1; dec_is_ret = 1'b1; dec_src_a = 4'h4;
      #1 expect_out("R9 ret cycle 1", 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      idle();
      #1 expect_out("R9 ret cycle 2", 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      #1 expect_out("R9 ret cycle 3", 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      #1 expect_out("R9 ret released", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R10: return behind a load it depends on
      @(negedge clk);
      idle();
      dec_valid = 1'b1; dec_is_ret = 1'b1; dec_src_a = 4'h5;
      exe_valid = 1'b1; exe_dst = 4'h5; exe_is_load = 1'b1;
      #1 expect_out("R10 load-use wins over ret", 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      exe_valid = 1'b0; exe_dst = 4'hF; exe_is_load = 1'b0;
      mem_valid = 1'b1; mem_dst = 4'h5;
      #1 expect_out("R10 ret window cycle 1", 2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      idle();
      #1 expect_out("R10 ret window cycle 2", 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      #1 expect_out("R10 ret window cycle 3", 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      #1 expect_out("R10 ret window over", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule